// File: doc/BRIEF.md
# Grouped Interrupt Combiner Register Bank

This block merges 32 level-sensitive interrupt sources into four groups of eight. Each group produces one combined request line for a primary interrupt controller upstream. Software reaches the block through a simple synchronous register bus. That bus has three registers, all 32 bits wide. One word turns enables on, a second word turns enables off, and a read-only word shows which enabled sources are currently active. Group n owns byte lane n of every register, bits [8n+7:8n]. This lets the four groups be managed independently through the same shared words.

Enables are never written directly. A one written to the set word turns the matching enable on. A one written to the clear word turns it off. Zero bits in either word leave their enables as they are, so no read-modify-write is needed. Status is live: a bit reads 1 only while its source input is high and its enable is on, and nothing is latched. Software reads status after a group request fires and picks which source to service.

Bus reads are combinational in the same cycle. The group request outputs are registered and follow the inputs one clock later. The asynchronous active-low reset is released through an internal synchronizer.

Top module: `irq_combiner_bank`

## Requirements
- R1: After reset every enable bit is 0, every grp_irq bit is 0, and a read of the status word (offset 0xC) returns 0 whatever the source inputs are.
- R2: A write to offset 0x0 sets each enable bit whose write-data bit is 1 and leaves every enable bit whose write-data bit is 0 unchanged.
- R3: A write to offset 0x4 clears each enable bit whose write-data bit is 1 and leaves every enable bit whose write-data bit is 0 unchanged.
- R4: Group n (n = 0..3) owns bits [8n+7:8n] of every register. Writing a byte mask such as 0x0000FF00 to offset 0x4 disables all eight sources of that group and leaves the enables of the other groups unchanged.
- R5: A read of offset 0xC returns src_in AND enable, bit by bit, as a live level. A bit drops as soon as its source input drops, with no latching.
- R6: grp_irq[n] is a register that, one clock edge after the inputs or enables change, equals the OR of the eight status bits of group n.
- R7: A read of offset 0x0 or 0x4 returns the current 32-bit enable vector.
- R8: A read of any offset other than 0x0, 0x4 and 0xC returns 0. bus_rdata is also 0 in any cycle that is not a read (bus_sel low, or bus_wr high).
- R9: A write to offset 0xC or to any offset other than 0x0 and 0x4 leaves every enable bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_in | input | 32 | Level-sensitive interrupt sources; bit 8n+k is source k of group n |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 set word, 0x4 clear word, 0xC status word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| grp_irq | output | 4 | Registered combined request, one bit per group |

## Verification
The bench attacks the masked-update semantics. It writes patterns with mixed ones and zeros and then reads the vector back. A design that wrote the word straight into the register instead of OR-ing or AND-NOT-ing it would lose enables that were set earlier. A full byte mask is cleared in one group while all sources are high. A lane-decode slip would then show up as a wrong request line or a wrong enable readback.

The status word is read again after a source drops. A latched status would keep a stale bit there. The request line is sampled in the cycle right after an enable write and again one cycle later. This catches a combinational output or a two-stage pipeline.

Writes to the status word, the unused word and unaligned offsets use data that would visibly set or clear enables if aliased. Reads of those offsets and idle cycles must return 0.

// File: rtl/cmb_pkg.sv
package cmb_pkg;
  localparam int GROUPS_DEF      = 4;
  localparam int SRC_PER_GRP_DEF = 8;
  localparam int ADDR_W_DEF      = 4;
  localparam int SYNC_STAGES_DEF = 2;

  localparam logic [3:0] OFS_EN_SET = 4'h0;
  localparam logic [3:0] OFS_EN_CLR = 4'h4;
  localparam logic [3:0] OFS_STATUS = 4'hC;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ENABLE = 2'd1,
    RD_STATUS = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic    wr_set;
    logic    wr_clr;
    rd_sel_e rd_sel;
  } bus_dec_t;
endpackage

// File: rtl/cmb_rst_sync.sv
module cmb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmb_bus_decode.sv
module cmb_bus_decode
  import cmb_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output bus_dec_t          dec
);
  logic hit_set;
  logic hit_clr;
  logic hit_sts;

  always_comb begin
    hit_set = (bus_addr == ADDR_W'(OFS_EN_SET));
    hit_clr = (bus_addr == ADDR_W'(OFS_EN_CLR));
    hit_sts = (bus_addr == ADDR_W'(OFS_STATUS));
    dec.wr_set = bus_sel && bus_wr && hit_set;
    dec.wr_clr = bus_sel && bus_wr && hit_clr;
    if (bus_sel && !bus_wr && (hit_set || hit_clr)) begin
      dec.rd_sel = RD_ENABLE;
    end else if (bus_sel && !bus_wr && hit_sts) begin
      dec.rd_sel = RD_STATUS;
    end else begin
      dec.rd_sel = RD_NONE;
    end
  end
endmodule

// File: rtl/cmb_enable_bank.sv
module cmb_enable_bank #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_set,
  input  logic              wr_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] en_vec
);
  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] en_d;
  logic [DATA_W-1:0] set_mask;
  logic [DATA_W-1:0] clr_mask;
  logic              en_upd;

  always_comb begin
    set_mask = wr_set ? wdata : '0;
    clr_mask = wr_clr ? wdata : '0;
    en_upd   = wr_set || wr_clr;
    // clear wins when both could touch a bit
    en_d     = (en_q | set_mask) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_upd) begin
      en_q <= en_d;
    end
  end

  assign en_vec = en_q;
endmodule

// File: rtl/cmb_group_merge.sv
module cmb_group_merge #(
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] src,
  input  logic [SRC_W-1:0] en,
  output logic [SRC_W-1:0] status,
  output logic             req
);
  logic req_q;
  logic req_d;

  always_comb begin
    status = src & en;
    req_d  = |status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else begin
      req_q <= req_d;
    end
  end

  assign req = req_q;
endmodule

// File: rtl/irq_combiner_bank.sv
module irq_combiner_bank
  import cmb_pkg::*;
#(
  parameter int GROUPS      = GROUPS_DEF,
  parameter int SRC_PER_GRP = SRC_PER_GRP_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int SYNC_STAGES = SYNC_STAGES_DEF,
  localparam int DATA_W     = GROUPS * SRC_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [GROUPS-1:0] grp_irq
);
  logic              rst_sync_n;
  bus_dec_t          dec;
  logic [DATA_W-1:0] en_vec;
  logic [DATA_W-1:0] status_vec;

  cmb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  cmb_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .dec      (dec)
  );

  cmb_enable_bank #(.DATA_W(DATA_W)) u_enables (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_set (dec.wr_set),
    .wr_clr (dec.wr_clr),
    .wdata  (bus_wdata),
    .en_vec (en_vec)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    cmb_group_merge #(.SRC_W(SRC_PER_GRP)) u_merge (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .src    (src_in[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .en     (en_vec[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .status (status_vec[g*SRC_PER_GRP +: SRC_PER_GRP]),
      .req    (grp_irq[g])
    );
  end

  always_comb begin
    unique case (dec.rd_sel)
      RD_ENABLE: bus_rdata = en_vec;
      RD_STATUS: bus_rdata = status_vec;
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_combiner_bank_chk.sv
module irq_combiner_bank_chk
  import cmb_pkg::*;
#(
  parameter int GROUPS      = 4,
  parameter int SRC_PER_GRP = 8,
  parameter int ADDR_W      = 4,
  localparam int DATA_W     = GROUPS * SRC_PER_GRP
) (
  input logic              clk,
  input logic              srst_n,
  input logic [DATA_W-1:0] src_in,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [GROUPS-1:0] grp_irq,
  input logic [DATA_W-1:0] en_vec
);
  logic a_set, a_clr, a_sts;

  always_comb begin
    a_set = (bus_addr == ADDR_W'(OFS_EN_SET));
    a_clr = (bus_addr == ADDR_W'(OFS_EN_CLR));
    a_sts = (bus_addr == ADDR_W'(OFS_STATUS));
  end

  AST_SET_ADDS_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && bus_wr && a_set) |=> en_vec == ($past(en_vec) | $past(bus_wdata))); // R2

  AST_CLR_REMOVES_ONLY: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && bus_wr && a_clr) |=> en_vec == ($past(en_vec) & ~$past(bus_wdata))); // R3

  AST_EN_HOLD_OTHER: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && bus_wr && (a_set || a_clr)) |=> $stable(en_vec)); // R9

  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && !bus_wr && a_sts) |-> bus_rdata == (src_in & en_vec)); // R5

  AST_ENABLE_READ: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_sel && !bus_wr && (a_set || a_clr)) |-> bus_rdata == en_vec); // R7

  AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_sel && !bus_wr && (a_set || a_clr || a_sts)) |-> bus_rdata == '0); // R8

  for (genvar g = 0; g < GROUPS; g++) begin : g_chk
    AST_GROUP_REQ: assert property (@(posedge clk) disable iff (!srst_n)
      grp_irq[g] == |($past(src_in[g*SRC_PER_GRP +: SRC_PER_GRP]) &
                      $past(en_vec[g*SRC_PER_GRP +: SRC_PER_GRP]))); // R6

    AST_LANE_ISOLATION: assert property (@(posedge clk) disable iff (!srst_n)
      (bus_sel && bus_wr && a_clr && bus_wdata[g*SRC_PER_GRP +: SRC_PER_GRP] == '0)
      |=> $stable(en_vec[g*SRC_PER_GRP +: SRC_PER_GRP])); // R4
  end
endmodule

bind irq_combiner_bank irq_combiner_bank_chk #(
  .GROUPS      (GROUPS),
  .SRC_PER_GRP (SRC_PER_GRP),
  .ADDR_W      (ADDR_W)
) u_chk (
  .clk       (clk),
  .srst_n    (rst_sync_n),
  .src_in    (src_in),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .grp_irq   (grp_irq),
  .en_vec    (en_vec)
);

// File: tb/irq_combiner_bank_test.sv
`timescale 1ns/1ps
module irq_combiner_bank_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] src_in;
  logic        bus_sel;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  grp_irq;

  int n_cmp;
  int n_bad;
  string phase;

  logic [31:0] m_en;
  logic [3:0]  m_irq;

  irq_combiner_bank uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_in    (src_in),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .grp_irq   (grp_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en  <= 32'h0;
      m_irq <= 4'h0;
    end else begin
      for (int g = 0; g < 4; g++) begin
        m_irq[g] <= (((src_in & m_en) >> (8 * g)) & 32'hFF) != 0;
      end
      if (bus_sel && bus_wr && bus_addr == 4'h0) m_en <= m_en | bus_wdata;
      else if (bus_sel && bus_wr && bus_addr == 4'h4) m_en <= m_en & ~bus_wdata;
    end
  end

  function automatic logic [31:0] model_rd();
    if (!(bus_sel && !bus_wr)) return 32'h0;
    if (bus_addr == 4'h0 || bus_addr == 4'h4) return m_en;
    if (bus_addr == 4'hC) return src_in & m_en;
    return 32'h0;
  endfunction

  // compare on every clock
  always @(posedge clk) begin
    #2;
    n_cmp++;
    if (grp_irq !== m_irq || bus_rdata !== model_rd()) begin
      n_bad++;
      $display("FAIL model %s: irq=%h rdata=%h expected irq=%h rdata=%h",
               phase, grp_irq, bus_rdata, m_irq, model_rd());
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    n_cmp = 0; n_bad = 0; phase = "reset";
    rst_n = 1'b0; src_in = 32'h0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = 32'h0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    phase = "R1";
    src_in = 32'hFFFF_FFFF;
    bus_read(4'h0, rd); check("R1 enable after reset", rd, 32'h0);
    bus_read(4'hC, rd); check("R1 status after reset", rd, 32'h0);
    idle(1);
    check("R1 grp_irq after reset", {28'h0, grp_irq}, 32'h0);
    src_in = 32'h0;
    idle(2);

    // R2 and R7: set word with mixed bits
    phase = "R2";
    bus_write(4'h0, 32'h0000_00A5);
    bus_read(4'h0, rd); check("R2 set pattern", rd, 32'h0000_00A5);
    bus_write(4'h0, 32'h0F00_0000);
    bus_read(4'h4, rd); check("R7 read at clear offset", rd, 32'h0F00_00A5);
    bus_read(4'h0, rd); check("R2 zeros keep earlier enables", rd, 32'h0F00_00A5);

    // R3: clear word with mixed bits
    phase = "R3";
    bus_write(4'h4, 32'h0000_0081);
    bus_read(4'h0, rd); check("R3 clear pattern", rd, 32'h0F00_0024);

    // R5 and R6: live status and group requests
    phase = "R5";
    src_in = 32'h0100_0004;
    bus_read(4'hC, rd); check("R5 status masked", rd, 32'h0100_0004);
    idle(1);
    check("R6 groups 0 and 3", {28'h0, grp_irq}, 32'h9);
    src_in = 32'h0100_0040;
    bus_read(4'hC, rd); check("R5 status not latched", rd, 32'h0100_0000);
    idle(1);
    check("R6 group 0 drops", {28'h0, grp_irq}, 32'h8);
    src_in = 32'h0;
    idle(2);
    check("R6 all low", {28'h0, grp_irq}, 32'h0);

    // R6: one-clock latency after an enable write
    phase = "R6";
    src_in = 32'h0001_0000;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h0; bus_wdata = 32'h00FF_0000;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 32'h0;
    check("R6 not yet after enable edge", {28'h0, grp_irq}, 32'h0);
    @(negedge clk);
    check("R6 one clock later", {28'h0, grp_irq}, 32'h4);

    // R4: clear one whole lane
    phase = "R4";
    bus_write(4'h0, 32'hFFFF_FFFF);
    src_in = 32'hFFFF_FFFF;
    bus_write(4'h4, 32'h0000_FF00);
    bus_read(4'h0, rd); check("R4 lane 1 cleared only", rd, 32'hFFFF_00FF);
    check("R4 requests without group 1", {28'h0, grp_irq}, 32'hD);
    bus_read(4'hC, rd); check("R4 status lanes", rd, 32'hFFFF_00FF);

    // R9: ignored writes
    phase = "R9";
    bus_write(4'hC, 32'h0000_FF00);
    bus_write(4'hC, 32'hFF00_0000);
    bus_write(4'h8, 32'h0000_FF00);
    bus_write(4'h8, 32'h0000_00FF);
    bus_write(4'h1, 32'hFFFF_FFFF);
    bus_write(4'h5, 32'hFFFF_FFFF);
    bus_read(4'h0, rd); check("R9 enables unchanged", rd, 32'hFFFF_00FF);

    // R8: undecoded reads and idle data
    phase = "R8";
    bus_read(4'h8, rd); check("R8 read 0x8", rd, 32'h0);
    bus_read(4'h1, rd); check("R8 read 0x1", rd, 32'h0);
    bus_read(4'hD, rd); check("R8 read 0xD", rd, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0;
    #1; check("R8 idle rdata", bus_rdata, 32'h0);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0;
    #1; check("R8 write cycle rdata", bus_rdata, 32'h0);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    src_in = 32'h0;
    idle(3);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule